// File: doc/BRIEF.md
# Temperature Conversion Request Controller

This block handles a conversion that software asks for ahead of the temperature compensation engine of a clock. Software writes 1 to a convert bit. The controller then starts one run of an external conversion engine. The sensor, the digitiser and the compensation arithmetic all sit outside this block; they are reached through a start pulse and a done pulse. The convert bit reads back as 1 while the request is waiting and while it runs. It clears at the same moment as the busy flag, once the engine reports done.

A free-running internal schedule also asks the engine for a run at a fixed interval. A user request never restarts or shifts that schedule. If both sources want a run, a single engine run serves both. No two engine starts are ever closer together than a minimum spacing (one second at the deployed clock rate). A request that arrives too early waits until the spacing has passed.

Top module: `temp_conv_ctrl`

## Requirements
- R1: During and after reset, `conv_bit`, `busy` and `eng_start` are 0.
- R2: With `conv_bit` at 0, a write of 1 (`cfg_wr_en`=1, `cfg_wr_conv`=1) sampled at a clock edge makes `conv_bit` read 1 after that edge. It stays 1 until its run completes.
- R3: A run begins with `eng_start` high for exactly one cycle, and `busy` rises in that same cycle. When the minimum spacing already allows it, the start comes one cycle after the write edge. No new start occurs while `busy` is high.
- R4: A done pulse sampled while `busy` is high ends the run. After that edge `busy` is 0. If the run served a user request, `conv_bit` falls in the same cycle.
- R5: Two `eng_start` pulses are never less than MIN_GAP_CYCLES cycles apart. A request that comes earlier is held, with `busy` low, and starts exactly MIN_GAP_CYCLES after the previous start.
- R6: Internal runs start every PERIOD_CYCLES cycles when nothing blocks them. During such a run `busy` is 1 and `conv_bit` stays 0.
- R7: User runs that take place between two internal runs do not move the next internal start away from its PERIOD_CYCLES slot.
- R8: While `conv_bit` is 1, a write of 0 leaves it at 1, and a further write of 1 starts no second run.
- R9: When a user request and a due internal run are pending together, one engine start serves both. `conv_bit` clears at that run's completion, and no extra start follows.
- R10: A done pulse while `busy` is 0 has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| cfg_wr_en | input | 1 | Register write strobe for the convert bit |
| cfg_wr_conv | input | 1 | Value written to the convert bit |
| eng_done | input | 1 | Single-cycle completion pulse from the conversion engine |
| conv_bit | output | 1 | Convert bit read-back (user request pending or running) |
| busy | output | 1 | An engine run (user or internal) is in progress |
| eng_start | output | 1 | Single-cycle start pulse to the conversion engine |

## Verification
The bench builds the block with PERIOD_CYCLES=400 and MIN_GAP_CYCLES=30 in place of multi-million-cycle defaults. With these values, several internal periods, a sequence of user runs between two internal slots, a request held back by the spacing rule, and a collision with a due internal run all fit in a few thousand cycles. Because the interval is short, the bench can measure it exactly, one start edge against the next, and compare it with the period and the spacing.

// File: rtl/tconv_pkg.sv
package tconv_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } tconv_state_e;
endpackage

// File: rtl/tconv_period.sv
// Free-running internal schedule: one due pulse every PERIOD_CYCLES cycles.
// Nothing but reset touches this counter.
module tconv_period #(
  parameter int unsigned PERIOD_CYCLES = 2097152
) (
  input  logic clk,
  input  logic rst_n,
  output logic due_o
);
  localparam int unsigned CW = (PERIOD_CYCLES > 1) ? $clog2(PERIOD_CYCLES) : 1;
  localparam logic [CW-1:0] CNT_TOP = CW'(PERIOD_CYCLES - 1);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    due_o = (cnt_q == CNT_TOP);
    cnt_d = due_o ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/tconv_spacing.sv
// Minimum spacing between engine starts; ok_o is high once MIN_GAP_CYCLES
// cycles have passed since the last launch.
module tconv_spacing #(
  parameter int unsigned MIN_GAP_CYCLES = 32768
) (
  input  logic clk,
  input  logic rst_n,
  input  logic launch_i,
  output logic ok_o
);
  localparam int unsigned CW = $clog2(MIN_GAP_CYCLES + 1);
  localparam logic [CW-1:0] GAP_MAX = CW'(MIN_GAP_CYCLES);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  always_comb begin
    ok_o   = (cnt_q == GAP_MAX);
    cnt_en = launch_i || !ok_o;
    cnt_d  = launch_i ? CW'(1) : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= GAP_MAX;
    else if (cnt_en) cnt_q <= cnt_d;
  end
endmodule

// File: rtl/tconv_ctrl_fsm.sv
// Request bookkeeping and engine handshake.
module tconv_ctrl_fsm
  import tconv_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic wr_set_i,
  input  logic due_i,
  input  logic gap_ok_i,
  input  logic eng_done_i,
  output logic launch_o,
  output logic conv_o,
  output logic busy_o,
  output logic start_o
);
  tconv_state_e state_q, state_d;
  logic conv_q, conv_d;
  logic int_pend_q, int_pend_d;
  logic run_user_q, run_user_d;
  logic start_q;
  logic finish;

  always_comb begin
    launch_o   = (state_q == ST_IDLE) && (conv_q || int_pend_q) && gap_ok_i;
    finish     = (state_q == ST_RUN) && eng_done_i;
    state_d    = state_q;
    if (launch_o)    state_d = ST_RUN;
    else if (finish) state_d = ST_IDLE;

    conv_d = conv_q;
    if (wr_set_i && !conv_q)      conv_d = 1'b1;
    else if (finish && run_user_q) conv_d = 1'b0;

    int_pend_d = int_pend_q;
    if (launch_o) int_pend_d = 1'b0;
    if (due_i)    int_pend_d = 1'b1;

    run_user_d = launch_o ? conv_q : run_user_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      conv_q     <= 1'b0;
      int_pend_q <= 1'b0;
      run_user_q <= 1'b0;
      start_q    <= 1'b0;
    end else begin
      state_q    <= state_d;
      conv_q     <= conv_d;
      int_pend_q <= int_pend_d;
      run_user_q <= run_user_d;
      start_q    <= launch_o;
    end
  end

  assign conv_o  = conv_q;
  assign busy_o  = (state_q == ST_RUN);
  assign start_o = start_q;
endmodule

// File: rtl/temp_conv_ctrl.sv
module temp_conv_ctrl #(
  parameter int unsigned PERIOD_CYCLES  = 2097152,
  parameter int unsigned MIN_GAP_CYCLES = 32768
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cfg_wr_en,
  input  logic cfg_wr_conv,
  input  logic eng_done,
  output logic conv_bit,
  output logic busy,
  output logic eng_start
);
  logic due, gap_ok, launch, wr_set;

  assign wr_set = cfg_wr_en && cfg_wr_conv;

  tconv_period #(.PERIOD_CYCLES(PERIOD_CYCLES)) u_period (
    .clk   (clk),
    .rst_n (rst_n),
    .due_o (due)
  );

  tconv_spacing #(.MIN_GAP_CYCLES(MIN_GAP_CYCLES)) u_spacing (
    .clk      (clk),
    .rst_n    (rst_n),
    .launch_i (launch),
    .ok_o     (gap_ok)
  );

  tconv_ctrl_fsm u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_set_i   (wr_set),
    .due_i      (due),
    .gap_ok_i   (gap_ok),
    .eng_done_i (eng_done),
    .launch_o   (launch),
    .conv_o     (conv_bit),
    .busy_o     (busy),
    .start_o    (eng_start)
  );
endmodule

// File: rtl/tconv_chk.sv
module tconv_chk #(
  parameter int unsigned MIN_GAP_CYCLES = 32768
) (
  input logic clk,
  input logic rst_n,
  input logic cfg_wr_en,
  input logic cfg_wr_conv,
  input logic eng_done,
  input logic conv_bit,
  input logic busy,
  input logic eng_start
);
  localparam int unsigned CW = $clog2(MIN_GAP_CYCLES + 1);
  localparam logic [CW-1:0] GAP_MAX = CW'(MIN_GAP_CYCLES);

  logic [CW-1:0] since_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  since_q <= GAP_MAX;
    else if (eng_start)          since_q <= CW'(1);
    else if (since_q != GAP_MAX) since_q <= since_q + 1'b1;
  end

  // R3
  start_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eng_start |=> !eng_start);
  // R3
  start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eng_start |-> busy);
  // R3
  no_start_while_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(eng_start) |-> !$past(busy));
  // R2
  conv_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(conv_bit) |-> $past(cfg_wr_en && cfg_wr_conv));
  // R4
  conv_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(conv_bit) |-> ($fell(busy) && $past(eng_done)));
  // R4
  busy_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(eng_done));
  // R5
  start_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eng_start |-> (since_q == GAP_MAX));
endmodule

bind temp_conv_ctrl tconv_chk #(.MIN_GAP_CYCLES(MIN_GAP_CYCLES)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .cfg_wr_en   (cfg_wr_en),
  .cfg_wr_conv (cfg_wr_conv),
  .eng_done    (eng_done),
  .conv_bit    (conv_bit),
  .busy        (busy),
  .eng_start   (eng_start)
);

// File: tb/temp_conv_ctrl_bench.sv
`timescale 1ns/1ps
module temp_conv_ctrl_bench;
  localparam int unsigned PERIOD = 400;
  localparam int unsigned GAP    = 30;
  localparam int WD_LIMIT = 20000;
  // user-run table: {done latency in cycles, poke writes during run}
  localparam int ROWS [4][2] = '{'{1, 0}, '{4, 1}, '{7, 0}, '{12, 1}};

  logic clk = 1'b0;
  logic rst_n;
  logic cfg_wr_en, cfg_wr_conv, eng_done;
  logic conv_bit, busy, eng_start;

  int cyc = 0;
  int tests = 0;
  int fails = 0;
  int start_cnt = 0;
  int last_start = 0;
  int prev_start = 0;
  int t1, t2, t3, n0;
  bit ok;

  always #2.5 clk = ~clk;

  temp_conv_ctrl #(.PERIOD_CYCLES(PERIOD), .MIN_GAP_CYCLES(GAP)) u_temp_conv_ctrl (
    .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .cfg_wr_conv(cfg_wr_conv),
    .eng_done(eng_done), .conv_bit(conv_bit), .busy(busy), .eng_start(eng_start)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == WD_LIMIT) begin
      fails++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  always @(negedge clk) begin
    if (eng_start) begin
      start_cnt++;
      prev_start = last_start;
      last_start = cyc;
    end
  end

  task automatic step();
    @(negedge clk);
    #0.2;
  endtask

  task automatic chk(string req, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wait_start(string req, output bit seen);
    seen = 1'b0;
    for (int i = 0; i < 1000; i++) begin
      step();
      if (eng_start) begin
        seen = 1'b1;
        break;
      end
    end
    tests++;
    if (!seen) begin
      fails++;
      $display("FAIL %s: actual no start expected start", req);
    end
  endtask

  task automatic pulse_done();
    eng_done = 1'b1;
    step();
    eng_done = 1'b0;
  endtask

  task automatic write_conv(logic v);
    cfg_wr_en = 1'b1;
    cfg_wr_conv = v;
    step();
    cfg_wr_en = 1'b0;
    cfg_wr_conv = 1'b0;
  endtask

  initial begin
    rst_n = 1'b0;
    cfg_wr_en = 1'b0;
    cfg_wr_conv = 1'b0;
    eng_done = 1'b0;
    for (int i = 0; i < 4; i++) step();
    // R1 during reset
    chk("R1 conv in reset", conv_bit, 0);
    chk("R1 busy in reset", busy, 0);
    chk("R1 start in reset", eng_start, 0);
    rst_n = 1'b1;
    step();
    chk("R1 conv after reset", conv_bit, 0);
    chk("R1 busy after reset", busy, 0);

    // R10 stray done while idle
    pulse_done();
    step();
    chk("R10 busy after idle done", busy, 0);
    chk("R10 conv after idle done", conv_bit, 0);
    chk("R10 no start after idle done", start_cnt, 0);

    // R6 first internal run
    wait_start("R6 first internal start", ok);
    t1 = last_start;
    chk("R6 busy in internal run", busy, 1);
    chk("R6 conv in internal run", conv_bit, 0);
    pulse_done();
    chk("R6 busy after internal done", busy, 0);
    for (int i = 0; i < GAP; i++) step();

    // table of user runs: R2, R3, R4, R8
    for (int r = 0; r < 4; r++) begin
      n0 = start_cnt;
      write_conv(1'b1);
      chk("R2 conv set after write", conv_bit, 1);
      chk("R3 busy before start", busy, 0);
      step();
      chk("R3 start one cycle after write", eng_start, 1);
      chk("R3 busy with start", busy, 1);
      for (int k = 1; k < ROWS[r][0]; k++) begin
        if (ROWS[r][1] != 0 && k == 1) write_conv(1'b0);
        else if (ROWS[r][1] != 0 && k == 2) write_conv(1'b1);
        else step();
        chk("R8 conv held during run", conv_bit, 1);
        chk("R3 busy held during run", busy, 1);
        chk("R3 start single cycle", eng_start, 0);
      end
      pulse_done();
      chk("R4 conv cleared at done", conv_bit, 0);
      chk("R4 busy cleared at done", busy, 0);
      for (int i = 0; i < GAP + 3; i++) step();
      chk("R8 no extra run", start_cnt, n0 + 1);
    end

    // R6 / R7 next internal slot unmoved
    wait_start("R6 second internal start", ok);
    t2 = last_start;
    chk("R7 internal period kept", t2 - t1, PERIOD);
    chk("R6 conv in internal run", conv_bit, 0);
    pulse_done();

    // R5 request held by spacing
    n0 = start_cnt;
    write_conv(1'b1);
    chk("R5 conv pending", conv_bit, 1);
    for (int i = 0; i < 10; i++) step();
    chk("R5 held busy low", busy, 0);
    chk("R5 held no start", start_cnt, n0);
    wait_start("R5 held start", ok);
    chk("R5 spacing exact", last_start - t2, GAP);
    pulse_done();
    chk("R4 conv cleared", conv_bit, 0);

    // R9 merged request
    t3 = t2 + PERIOD;
    while (cyc < t3 - 17) step();
    write_conv(1'b1);
    wait_start("R9 user start before slot", ok);
    chk("R9 user start edge", last_start, t3 - 15);
    pulse_done();
    while (cyc < t3 + 5) step();
    n0 = start_cnt;
    write_conv(1'b1);
    wait_start("R9 merged start", ok);
    chk("R9 merged start edge", last_start, t3 - 15 + GAP);
    chk("R9 conv during merged run", conv_bit, 1);
    pulse_done();
    chk("R9 conv cleared", conv_bit, 0);
    chk("R9 busy cleared", busy, 0);
    for (int i = 0; i < GAP + 5; i++) step();
    chk("R9 single run", start_cnt, n0 + 1);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule